// File: doc/BRIEF.md
# Masked CAN Identifier Acceptance Filter

This block picks the receive message buffer, if any, that takes an incoming CAN frame. Each of the sixteen buffers has a 29-bit identifier, an IDE flag, an enable bit and a receive-empty flag. Three 32-bit mask registers decide which identifier bits must match. Buffers 0 to 13 share a common mask. Buffer 14 and buffer 15 each have a mask of their own. A mask bit set to 1 makes the matching identifier bit significant. A mask bit set to 0 makes that bit don't-care. The IDE bit is always compared. The RTR/SRR position never takes part, and a remote frame never lands in any buffer.

A frame is presented for one cycle with `frm_valid`. The result appears on the next cycle: `res_valid` is high, `res_hit` says whether a buffer accepted the frame, and `res_idx` gives the lowest-numbered buffer that accepted it. A small control machine has two states. **ST_WAIT** means no result is on the outputs. **ST_RESULT** means a result is being shown for one cycle. The machine has four transitions:
- *accept* (ST_WAIT to ST_RESULT on a frame)
- *retire* (ST_RESULT to ST_WAIT with no frame)
- *chain* (ST_RESULT to ST_RESULT on a back-to-back frame)
- *idle* (ST_WAIT to ST_WAIT)

The host writes and reads the masks through a simple select/data port. Three positions are fixed: bit 19 always reads 1, and bits 20 and 0 always read 0.

Top module: `canf_filter`

## Requirements
- R1: After reset all three mask registers read 32'hFFEF_FFFE.
- R2: A mask write stores the written data, except at the fixed positions: bit 19 reads as 1 and bits 20 and 0 read as 0, whatever was written.
- R3: The mask select code is 0 for the shared mask, 1 for the mask of buffer 14 and 2 for the mask of buffer 15. A write with code 3 changes nothing, and a read with code 3 returns 0.
- R4: Mask bits 31:21 govern identifier bits 28:18 for both frame formats. Mask bits 18:1 govern identifier bits 17:0, and only for extended frames (`rx_ide`=1). A mask bit of 1 requires equality with the buffer identifier, and a mask bit of 0 makes the bit don't-care.
- R5: The received IDE bit must always equal the buffer's IDE bit, whatever the mask holds.
- R6: A frame with `rx_rtr`=1 never produces a hit.
- R7: Buffers 0 to 13 are filtered with the shared mask. Buffer 14 uses mask code 1 and buffer 15 uses mask code 2.
- R8: Only buffers with both `mb_en` and `mb_rxe` set can accept a frame.
- R9: When several buffers accept a frame, `res_idx` is the lowest index among them.
- R10: `res_valid` is high exactly in the cycle after a cycle with `frm_valid` high. When there is no hit, `res_hit` and `res_idx` are 0. Frames may arrive on consecutive cycles.
- R11: A mask write in the same cycle as a frame takes effect only for later frames. That frame is filtered with the old mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Mask write strobe |
| mask_wr_sel | input | 2 | Mask select for write (R3 codes) |
| mask_wdata | input | 32 | Mask write data |
| mask_rd_sel | input | 2 | Mask select for read |
| mask_rdata | output | 32 | Mask read data, fixed positions applied |
| frm_valid | input | 1 | Received frame present this cycle |
| rx_id | input | 29 | Received identifier; bits 28:18 hold a standard identifier |
| rx_ide | input | 1 | Received frame is extended |
| rx_rtr | input | 1 | Received frame is a remote request |
| mb_en | input | 16 | Per-buffer enable |
| mb_rxe | input | 16 | Per-buffer receive-empty flag |
| mb_id | input | 464 | Buffer identifiers, buffer n at bits n*29+28 : n*29 |
| mb_ide | input | 16 | Per-buffer IDE setting |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A buffer accepted the frame |
| res_idx | output | 4 | Index of the accepting buffer |

## Verification
Two things can happen in the same cycle: a mask write and the filtering of a frame. Only the frame captured at that edge has to see the old mask. A directed case sends a frame that matches only under the new mask while the write is happening. It expects a miss, and then a hit on the next frame. The random phase also overlaps writes with frames. It judges every cycle against a reference model that computes the result before it applies the write.

// File: rtl/canf_pkg.sv
package canf_pkg;
    localparam int unsigned MASK_W     = 32;
    localparam int unsigned STD_ID_W   = 11;
    localparam int unsigned EXT_ID_W   = 18;
    localparam int unsigned ID_W       = STD_ID_W + EXT_ID_W;
    localparam int unsigned NUM_MASK   = 3;
    localparam int unsigned SEL_W      = 2;
    localparam int unsigned IDE_POS    = 19;
    localparam int unsigned RTR_HI_POS = 20;
    localparam int unsigned RTR_LO_POS = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_SHARED = 2'd0,
        SEL_DED_A  = 2'd1,
        SEL_DED_B  = 2'd2,
        SEL_NONE   = 2'd3
    } mask_sel_e;

    typedef enum logic {
        ST_WAIT   = 1'b0,
        ST_RESULT = 1'b1
    } filt_state_e;

    // Apply the fixed mask positions: IDE compared, RTR/SRR never.
    function automatic logic [MASK_W-1:0] force_fixed(input logic [MASK_W-1:0] v);
        logic [MASK_W-1:0] r;
        r = v;
        r[IDE_POS]    = 1'b1;
        r[RTR_HI_POS] = 1'b0;
        r[RTR_LO_POS] = 1'b0;
        return r;
    endfunction

    // Repack a mask so that bit k lines up with identifier bit k.
    function automatic logic [ID_W-1:0] cmp_view(input logic [MASK_W-1:0] v);
        return {v[MASK_W-1 -: STD_ID_W], v[RTR_HI_POS-2 -: EXT_ID_W]};
    endfunction
endpackage

// File: rtl/canf_mask_bank.sv
module canf_mask_bank
    import canf_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [MASK_W-1:0]               wr_data,
    input  logic [SEL_W-1:0]                rd_sel,
    output logic [MASK_W-1:0]               rd_data,
    output logic [NUM_MASK-1:0][ID_W-1:0]   cmp
);
    logic [MASK_W-1:0] bank [NUM_MASK];

    for (genvar g = 0; g < NUM_MASK; g++) begin : g_reg
        logic [MASK_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= force_fixed('1);
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                q <= force_fixed(wr_data);
            end
        end
        assign bank[g] = q;
        assign cmp[g]  = cmp_view(q);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_MASK; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = force_fixed(bank[i]);
            end
        end
    end
endmodule

// File: rtl/canf_id_match.sv
module canf_id_match
    import canf_pkg::*;
(
    input  logic [ID_W-1:0] cmp,
    input  logic [ID_W-1:0] rx_id,
    input  logic            rx_ide,
    input  logic [ID_W-1:0] mb_id,
    input  logic            mb_ide,
    input  logic            eligible,
    output logic            hit
);
    logic [ID_W-1:0] span;
    logic [ID_W-1:0] miss;

    // Standard frames only look at the upper identifier field.
    assign span = {{STD_ID_W{1'b1}}, {EXT_ID_W{rx_ide}}};
    assign miss = (rx_id ^ mb_id) & cmp & span;
    assign hit  = eligible & ~(rx_ide ^ mb_ide) & ~(|miss);
endmodule

// File: rtl/canf_low_pick.sv
module canf_low_pick #(
    parameter int unsigned N     = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/canf_filter.sv
module canf_filter
    import canf_pkg::*;
#(
    parameter int unsigned NUM_MB = 16,
    parameter int unsigned DED_A  = 14,
    parameter int unsigned DED_B  = 15,
    localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mask_wr,
    input  logic [1:0]             mask_wr_sel,
    input  logic [31:0]            mask_wdata,
    input  logic [1:0]             mask_rd_sel,
    output logic [31:0]            mask_rdata,
    input  logic                   frm_valid,
    input  logic [28:0]            rx_id,
    input  logic                   rx_ide,
    input  logic                   rx_rtr,
    input  logic [NUM_MB-1:0]      mb_en,
    input  logic [NUM_MB-1:0]      mb_rxe,
    input  logic [NUM_MB*29-1:0]   mb_id,
    input  logic [NUM_MB-1:0]      mb_ide,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [IDX_W-1:0]       res_idx
);
    logic [NUM_MASK-1:0][ID_W-1:0] cmp_all;
    logic [NUM_MB-1:0]             req;
    logic                          any;
    logic [IDX_W-1:0]              pick;
    filt_state_e                   state_q, state_d;
    logic                          hit_q;
    logic [IDX_W-1:0]              idx_q;

    canf_mask_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr),
        .wr_sel  (mask_wr_sel),
        .wr_data (mask_wdata),
        .rd_sel  (mask_rd_sel),
        .rd_data (mask_rdata),
        .cmp     (cmp_all)
    );

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        localparam int unsigned MSEL = (g == DED_A) ? int'(SEL_DED_A) :
                                       (g == DED_B) ? int'(SEL_DED_B) :
                                                      int'(SEL_SHARED);
        canf_id_match u_match (
            .cmp      (cmp_all[MSEL]),
            .rx_id    (rx_id),
            .rx_ide   (rx_ide),
            .mb_id    (mb_id[g*ID_W +: ID_W]),
            .mb_ide   (mb_ide[g]),
            .eligible (mb_en[g] & mb_rxe[g] & ~rx_rtr),
            .hit      (req[g])
        );
    end

    canf_low_pick #(.N(NUM_MB)) u_pick (
        .req (req),
        .any (any),
        .idx (pick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, retire, chain, idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   state_d = frm_valid ? ST_RESULT : ST_WAIT;
            ST_RESULT: state_d = frm_valid ? ST_RESULT : ST_WAIT;
        endcase
    end

    // Result outputs, captured with the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else if (frm_valid) begin
            hit_q <= any;
            idx_q <= any ? pick : '0;
        end else begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
    assign res_hit   = hit_q;
    assign res_idx   = idx_q;
endmodule

// File: rtl/canf_filter_chk.sv
module canf_filter_chk #(
    parameter int unsigned NUM_MB = 16,
    localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic              rx_rtr,
    input logic [NUM_MB-1:0] mb_en,
    input logic [NUM_MB-1:0] mb_rxe,
    input logic [1:0]        mask_rd_sel,
    input logic [31:0]       mask_rdata,
    input logic              res_valid,
    input logic              res_hit,
    input logic [IDX_W-1:0]  res_idx
);
    logic [NUM_MB-1:0] elig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= mb_en & mb_rxe;
    end

    a_r2_ide_pos_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd_sel != 2'd3) |-> mask_rdata[19]);

    a_r2_rtr_pos_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rdata[20] && !mask_rdata[0]);

    a_r3_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd_sel == 2'd3) |-> (mask_rdata == 32'h0));

    a_r6_remote_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && rx_rtr) |=> !res_hit);

    a_r8_hit_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> elig_q[res_idx]);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    a_r10_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_idx == '0));
endmodule

bind canf_filter canf_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_valid   (frm_valid),
    .rx_rtr      (rx_rtr),
    .mb_en       (mb_en),
    .mb_rxe      (mb_rxe),
    .mask_rd_sel (mask_rd_sel),
    .mask_rdata  (mask_rdata),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_idx     (res_idx)
);

// File: tb/sim_canf_filter.sv
`timescale 1ns/1ps
module sim_canf_filter;
    localparam int NMB = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mask_wr = 1'b0;
    logic [1:0]        mask_wr_sel = '0;
    logic [31:0]       mask_wdata = '0;
    logic [1:0]        mask_rd_sel = '0;
    logic [31:0]       mask_rdata;
    logic              frm_valid = 1'b0;
    logic [28:0]       rx_id = '0;
    logic              rx_ide = 1'b0;
    logic              rx_rtr = 1'b0;
    logic [NMB-1:0]    mb_en = '0;
    logic [NMB-1:0]    mb_rxe = '0;
    logic [NMB*29-1:0] mb_id = '0;
    logic [NMB-1:0]    mb_ide = '0;
    logic              res_valid;
    logic              res_hit;
    logic [3:0]        res_idx;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_mask [3];
    bit          e_valid;
    bit          e_hit;
    int          e_idx;

    always #4 clk = ~clk;

    canf_filter u0 (.*);

    function automatic logic [31:0] fixv(input logic [31:0] v);
        logic [31:0] r;
        r = v | 32'h0008_0000;
        r = r & ~32'h0010_0001;
        return r;
    endfunction

    function automatic bit ref_accept(input int b);
        int mi;
        int mpos;
        mi = (b == 14) ? 1 : (b == 15) ? 2 : 0;
        if (rx_ide != mb_ide[b]) return 1'b0;
        for (int k = 0; k < 29; k++) begin
            if (!rx_ide && k < 18) continue;
            mpos = (k >= 18) ? k + 3 : k + 1;
            if (m_mask[mi][mpos] && (rx_id[k] != mb_id[b*29 + k])) return 1'b0;
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_mask[i] = 32'hFFEF_FFFE;
            e_valid = 1'b0; e_hit = 1'b0; e_idx = 0;
        end else begin
            e_valid = frm_valid; e_hit = 1'b0; e_idx = 0;
            if (frm_valid && !rx_rtr) begin
                for (int b = 0; b < NMB; b++) begin
                    if (!e_hit && mb_en[b] && mb_rxe[b] && ref_accept(b)) begin
                        e_hit = 1'b1; e_idx = b;
                    end
                end
            end
            if (mask_wr && mask_wr_sel != 2'd3) m_mask[mask_wr_sel] = fixv(mask_wdata);
        end
    end

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [31:0] e_rd;
            e_rd = (mask_rd_sel == 2'd3) ? 32'h0 : m_mask[mask_rd_sel];
            chk({cur_req, " res_valid"}, res_valid === e_valid, res_valid, e_valid);
            chk({cur_req, " res_hit"}, res_hit === e_hit, res_hit, e_hit);
            chk({cur_req, " res_idx"}, res_idx === 4'(e_idx), res_idx, e_idx);
            chk({cur_req, " mask_rdata"}, mask_rdata === e_rd, mask_rdata, e_rd);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_mask(input logic [1:0] sel, input logic [31:0] d);
        mask_wr = 1'b1; mask_wr_sel = sel; mask_wdata = d;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
        mask_rd_sel = sel;
        #1;
        chk(tag, mask_rdata === exp, mask_rdata, exp);
    endtask

    task automatic set_mb(input int b, input logic [28:0] id, input bit ide, input bit en, input bit rxe);
        mb_id[b*29 +: 29] = id; mb_ide[b] = ide; mb_en[b] = en; mb_rxe[b] = rxe;
    endtask

    task automatic send_chk(input string tag, input logic [28:0] id, input bit ide, input bit rtr,
                            input bit exp_hit, input int exp_idx);
        frm_valid = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
        step();
        frm_valid = 1'b0; rx_rtr = 1'b0;
        #1;
        chk({tag, " hit"}, res_hit === exp_hit, res_hit, exp_hit);
        chk({tag, " idx"}, res_idx === 4'(exp_idx), res_idx, exp_idx);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [28:0] ida, idb, idc;
        ida = 29'h0ABC_DEF1; idb = 29'h1234_5678; idc = 29'h0765_4321;
        step(4);
        rst_n = 1'b1;
        step();
        cmp_on = 1'b1;

        cur_req = "R1";
        rd_chk("R1 shared reset", 2'd0, 32'hFFEF_FFFE);
        rd_chk("R1 mask14 reset", 2'd1, 32'hFFEF_FFFE);
        rd_chk("R1 mask15 reset", 2'd2, 32'hFFEF_FFFE);

        cur_req = "R3";
        wr_mask(2'd3, 32'h0);
        rd_chk("R3 shared untouched", 2'd0, 32'hFFEF_FFFE);
        rd_chk("R3 mask14 untouched", 2'd1, 32'hFFEF_FFFE);
        rd_chk("R3 mask15 untouched", 2'd2, 32'hFFEF_FFFE);
        rd_chk("R3 code3 reads zero", 2'd3, 32'h0);

        cur_req = "R2";
        wr_mask(2'd1, 32'h0);
        rd_chk("R2 zeros write", 2'd1, 32'h0008_0000);
        wr_mask(2'd1, 32'hFFFF_FFFF);
        rd_chk("R2 ones write", 2'd1, 32'hFFEF_FFFE);
        wr_mask(2'd2, 32'h5A5A_A5A5);
        rd_chk("R2 pattern write", 2'd2, 32'h5A4A_A5A4);
        wr_mask(2'd2, 32'hFFFF_FFFF);
        mask_rd_sel = 2'd0;

        cur_req = "R4";
        set_mb(3, ida, 1'b0, 1'b1, 1'b1);
        send_chk("R4 std exact", ida, 1'b0, 1'b0, 1'b1, 3);
        send_chk("R4 std id18 differs", ida ^ 29'h0004_0000, 1'b0, 1'b0, 1'b0, 0);
        send_chk("R4 std low bits ignored", ida ^ 29'h1, 1'b0, 1'b0, 1'b1, 3);
        wr_mask(2'd0, 32'hFFDF_FFFF);
        send_chk("R4 mask21 dont care", ida ^ 29'h0004_0000, 1'b0, 1'b0, 1'b1, 3);
        wr_mask(2'd0, 32'hFFFF_FFFF);
        set_mb(4, idb, 1'b1, 1'b1, 1'b1);
        send_chk("R4 ext exact", idb, 1'b1, 1'b0, 1'b1, 4);
        send_chk("R4 ext id0 differs", idb ^ 29'h1, 1'b1, 1'b0, 1'b0, 0);
        wr_mask(2'd0, 32'hFFFF_FFFD);
        send_chk("R4 mask1 dont care", idb ^ 29'h1, 1'b1, 1'b0, 1'b1, 4);

        cur_req = "R5";
        wr_mask(2'd0, 32'h0);
        send_chk("R5 ide0 frame", idb, 1'b0, 1'b0, 1'b1, 3);
        send_chk("R5 ide1 frame", idb, 1'b1, 1'b0, 1'b1, 4);

        cur_req = "R6";
        send_chk("R6 remote rejected", ida, 1'b0, 1'b1, 1'b0, 0);

        cur_req = "R7";
        set_mb(3, ida, 1'b0, 1'b0, 1'b1);
        set_mb(4, idb, 1'b1, 1'b0, 1'b1);
        set_mb(14, idc, 1'b0, 1'b1, 1'b1);
        set_mb(15, idc, 1'b0, 1'b1, 1'b1);
        wr_mask(2'd1, 32'hFFFF_FFFF);
        wr_mask(2'd2, 32'h0);
        send_chk("R7 own mask of 15", idc ^ 29'h0010_0000, 1'b0, 1'b0, 1'b1, 15);
        send_chk("R7 own mask of 14", idc, 1'b0, 1'b0, 1'b1, 14);

        cur_req = "R8";
        mb_en[14] = 1'b0;
        send_chk("R8 disabled skipped", idc, 1'b0, 1'b0, 1'b1, 15);
        mb_rxe[15] = 1'b0;
        send_chk("R8 not empty skipped", idc, 1'b0, 1'b0, 1'b0, 0);

        cur_req = "R9";
        wr_mask(2'd0, 32'hFFFF_FFFF);
        set_mb(9, idc, 1'b0, 1'b1, 1'b1);
        set_mb(6, idc, 1'b0, 1'b1, 1'b1);
        mb_en[14] = 1'b1;
        send_chk("R9 lowest wins", idc, 1'b0, 1'b0, 1'b1, 6);

        cur_req = "R10";
        frm_valid = 1'b1; rx_id = idc; rx_ide = 1'b0;
        step();
        rx_id = ida;
        #1;
        chk("R10 first of burst", res_valid && res_hit && res_idx == 4'd6, {res_valid, res_hit, res_idx}, 6'h36);
        step();
        frm_valid = 1'b0;
        #1;
        chk("R10 second of burst", res_valid && !res_hit && res_idx == 4'd0, {res_valid, res_hit, res_idx}, 6'h20);
        step();
        #1;
        chk("R10 valid drops", !res_valid, res_valid, 0);

        cur_req = "R11";
        mask_wr = 1'b1; mask_wr_sel = 2'd0; mask_wdata = 32'h0;
        frm_valid = 1'b1; rx_id = idc ^ 29'h0010_0000; rx_ide = 1'b0;
        step();
        mask_wr = 1'b0; frm_valid = 1'b0;
        #1;
        chk("R11 old mask used", !res_hit, res_hit, 0);
        step();
        send_chk("R11 new mask later", idc ^ 29'h0010_0000, 1'b0, 1'b0, 1'b1, 6);

        cur_req = "R9";
        for (int it = 0; it < 1500; it++) begin
            int b;
            logic [28:0] id;
            mb_en = 16'($urandom);
            mb_rxe = 16'($urandom) | 16'($urandom);
            mb_ide = 16'($urandom);
            for (int j = 0; j < NMB; j++) mb_id[j*29 +: 29] = 29'($urandom);
            b = $urandom_range(0, NMB - 1);
            id = mb_id[b*29 +: 29];
            if ($urandom_range(0, 1) == 1) id = id ^ (29'h1 << $urandom_range(0, 28));
            if ($urandom_range(0, 3) == 0) begin
                mask_wr = 1'b1; mask_wr_sel = 2'($urandom); mask_wdata = $urandom;
            end
            mask_rd_sel = 2'($urandom);
            frm_valid = 1'b1; rx_id = id;
            rx_ide = ($urandom_range(0, 7) == 0) ? ~mb_ide[b] : mb_ide[b];
            rx_rtr = ($urandom_range(0, 7) == 0);
            step();
            mask_wr = 1'b0;
            if ($urandom_range(0, 2) != 0) frm_valid = 1'b0;
            step();
            frm_valid = 1'b0;
        end
        step(2);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule